// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a small processor that finishes each instruction in one clock cycle. It executes a fixed subset: word load and store, five register-register operations (add, subtract, and, or, signed set-less-than), a branch taken when two registers match, and an unconditional jump. The program counter, a 32-entry register file, the ALU, sign extension, a two-level decoder and the datapath selectors are all inside. The instruction and data stores are small word arrays held in the block.

The stores are filled through a load port while reset is held. Releasing reset starts execution at address zero. Final results are read through two combinational debug ports, one for a register and one for a data word. The current program counter is a registered output.

ALU control is decoded in two levels. The main decoder sends a 2-bit class code. For register-register instructions only, the function field then refines that code into a 4-bit ALU operation.

Top module: `sc_cpu`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears every register. While reset is asserted, no instruction writes a register or the data store.
- R2: Opcode 000000 is a register-register instruction. Its function field selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 set-less-than. The operands are the registers named in bits 25:21 and 20:16, and the result goes to the register named in bits 15:11.
- R3: Set-less-than writes 1 when the first operand is below the second as a signed 32-bit number, and 0 otherwise. Its result bits 31:1 are always zero.
- R4: Opcode 100011 loads a word. The byte address is the bits 25:21 register plus the sign-extended bits 15:0. The word at that address divided by four is written to the register named in bits 20:16.
- R5: Opcode 101011 stores the bits 20:16 register at the address formed as in R4.
- R6: Register 0 always reads as zero, and writes to it are ignored.
- R7: Every instruction that is not a taken branch or a jump advances the program counter by 4.
- R8: Opcode 000100 compares the registers in bits 25:21 and 20:16. When they are equal, the next program counter is PC+4 plus the sign-extended bits 15:0 shifted left by 2; backward offsets are allowed. Otherwise it is PC+4.
- R9: Opcode 000010 jumps to the address formed by bits 31:28 of PC+4, then instruction bits 25:0, then two zero bits.
- R10: Any other opcode writes no state and advances the program counter by 4.
- R11: With `ld_en` high, `ld_data` is written to word `ld_addr` of the data store when `ld_dmem` is 1, and of the instruction store when `ld_dmem` is 0. The debug ports return register `dbg_reg` and data word `dbg_mem` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load target: 1 data store, 0 instruction store |
| ld_addr | input | MEM_AW | Word index for the load port |
| ld_data | input | 32 | Word to load |
| dbg_reg | input | 5 | Register number to observe |
| dbg_mem | input | MEM_AW | Data word index to observe |
| pc_out | output | 32 | Current program counter |
| dbg_reg_data | output | 32 | Value of register `dbg_reg` |
| dbg_mem_data | output | 32 | Value of data word `dbg_mem` |

## Verification
A fixed arithmetic program runs once for every ordered pair drawn from eight operands: zero, one, minus one, seven, the largest and smallest signed values, a mixed pattern and minus seven. The signed extremes separate signed from unsigned comparison and expose wrap-around in add and subtract. Swapping the operands catches operand-order mistakes in subtract and set-less-than. A second program checks control flow. It contains a taken forward branch, a branch that is not taken, a jump over two instructions, an undefined opcode, and a backward branch onto itself that holds the final PC. The expected PC tells these paths apart.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_class_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  typedef struct packed {
    logic       dst_rd;
    logic       b_imm;
    logic       wb_mem;
    logic       reg_we;
    logic       mem_we;
    logic       branch;
    logic       jump;
    alu_class_e cls;
  } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl     = '0;
    ctrl.cls = CLS_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.cls    = CLS_FUNCT;
      end
      OP_LW: begin
        ctrl.b_imm  = 1'b1;
        ctrl.wb_mem = 1'b1;
        ctrl.reg_we = 1'b1;
      end
      OP_SW: begin
        ctrl.b_imm  = 1'b1;
        ctrl.mem_we = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.cls    = CLS_SUB;
      end
      OP_J: begin
        ctrl.jump = 1'b1;
      end
      default: begin
        ctrl     = '0;
        ctrl.cls = CLS_ADD;
      end
    endcase
  end

endmodule

// File: rtl/sc_alu_ctl.sv
module sc_alu_ctl
  import sc_pkg::*;
(
  input  alu_class_e cls,
  input  logic [5:0] funct,
  output alu_op_e    op
);

  always_comb begin
    case (cls)
      CLS_ADD: op = ALU_ADD;
      CLS_SUB: op = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_ADD:  op = ALU_ADD;
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          default: op = ALU_ADD;
        endcase
      end
      default: op = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  input  logic [$clog2(NREG)-1:0] ra3,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2,
  output logic [W-1:0]            rd3
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

  // R6: a write to a nonzero register is visible on the next cycle
  a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
  import sc_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  input  logic [4:0]        dbg_reg,
  input  logic [MEM_AW-1:0] dbg_mem,
  output logic [31:0]       pc_out,
  output logic [31:0]       dbg_reg_data,
  output logic [31:0]       dbg_mem_data
);

  localparam int WORDS = 1 << MEM_AW;

  logic [31:0] imem [WORDS];
  logic [31:0] dmem [WORDS];

  logic [31:0] pc_q, pc_plus4, br_target, j_target, pc_next;
  logic [31:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, mem_rd, wb_data;
  logic [MEM_AW-1:0] imem_idx, dmem_idx;
  logic [4:0]  rf_wa;
  ctrl_t       ctrl;
  alu_op_e     alu_ctl;
  logic        alu_zero, br_take;
  logic        unused_bits;

  // fetch
  assign imem_idx = pc_q[MEM_AW+1:2];
  assign instr    = imem[imem_idx];

  // decode
  sc_main_dec u_main_dec (
    .opcode (instr[31:26]),
    .ctrl   (ctrl)
  );

  sc_alu_ctl u_alu_ctl (
    .cls   (ctrl.cls),
    .funct (instr[5:0]),
    .op    (alu_ctl)
  );

  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign rf_wa   = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.NREG(32), .W(32)) u_regfile (
    .clk (clk),
    .rst (rst),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .ra3 (dbg_reg),
    .we  (ctrl.reg_we),
    .wa  (rf_wa),
    .wd  (wb_data),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .rd3 (dbg_reg_data)
  );

  // execute
  assign alu_b = ctrl.b_imm ? imm_ext : rt_val;

  sc_alu #(.W(32)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (alu_ctl),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // memory and write-back
  assign dmem_idx = alu_y[MEM_AW+1:2];
  assign mem_rd   = dmem[dmem_idx];
  assign wb_data  = ctrl.wb_mem ? mem_rd : alu_y;

  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_dmem)
      dmem[ld_addr] <= ld_data;
    else if (!rst && ctrl.mem_we)
      dmem[dmem_idx] <= rt_val;
  end

  assign dbg_mem_data = dmem[dbg_mem];

  // next program counter
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign br_take   = ctrl.branch & alu_zero;
  assign pc_next   = ctrl.jump ? j_target : (br_take ? br_target : pc_plus4);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_out = pc_q;

  assign unused_bits = ^{pc_q[1:0], pc_q[31:MEM_AW+2], alu_y[1:0],
                         alu_y[31:MEM_AW+2], instr[10:6]};

  // R7: sequential advance
  a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !br_take) |=> pc_q == $past(pc_q) + 32'd4);

  // R8: taken branch lands on the offset target
  a_r8_branch_target: assert property (@(posedge clk) disable iff (rst)
    br_take |=> pc_q == $past(br_target));

  // R9: jump lands on the concatenated target
  a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> pc_q == {$past(pc_plus4[31:28]), $past(instr[25:0]), 2'b00});

  // R4: a load writes the register from bits 20:16
  a_r4_load_dest: assert property (@(posedge clk) disable iff (rst)
    ctrl.wb_mem |-> (ctrl.reg_we && rf_wa == instr[20:16]));

  // R2: register-register results go to bits 15:11
  a_r2_rtype_dest: assert property (@(posedge clk) disable iff (rst)
    (ctrl.reg_we && !ctrl.wb_mem) |-> rf_wa == instr[15:11]);

  // R5: a store leaves the source register value in the addressed word
  a_r5_store_lands: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mem_we && !ld_en) |=> dmem[$past(dmem_idx)] == $past(rt_val));

  // R3: set-less-than yields a single bit
  a_r3_slt_one_bit: assert property (@(posedge clk) disable iff (rst)
    (alu_ctl == ALU_SLT) |-> alu_y[31:1] == '0);

endmodule

// File: tb/test_sc_cpu.sv
module test_sc_cpu;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_en = 1'b0;
  logic              ld_dmem = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [31:0]       ld_data = '0;
  logic [4:0]        dbg_reg = '0;
  logic [MEM_AW-1:0] dbg_mem = '0;
  logic [31:0]       pc_out, dbg_reg_data, dbg_mem_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_cpu #(.MEM_AW(MEM_AW)) i_sc_cpu (
    .clk (clk), .rst (rst), .ld_en (ld_en), .ld_dmem (ld_dmem),
    .ld_addr (ld_addr), .ld_data (ld_data), .dbg_reg (dbg_reg),
    .dbg_mem (dbg_mem), .pc_out (pc_out), .dbg_reg_data (dbg_reg_data),
    .dbg_mem_data (dbg_mem_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] operand(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0007;
      4: return 32'h7FFF_FFFF;
      5: return 32'h8000_0000;
      6: return 32'h1234_5678;
      default: return 32'hFFFF_FFF9;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(logic sel, int addr, logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = sel; ld_addr = addr[MEM_AW-1:0]; ld_data = d;
    @(posedge clk);
    #1 ld_en = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_reg(int idx, output logic [31:0] v);
    dbg_reg = idx[4:0];
    #1 v = dbg_reg_data;
  endtask

  task automatic rd_mem(int idx, output logic [31:0] v);
    dbg_mem = idx[MEM_AW-1:0];
    #1 v = dbg_mem_data;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b, v;

    // arithmetic program
    load(0, 0,  enc_i(6'b100011, 0, 1, 0));
    load(0, 1,  enc_i(6'b100011, 0, 2, 4));
    load(0, 2,  enc_r(1, 2, 3, 6'b100000));
    load(0, 3,  enc_r(1, 2, 4, 6'b100010));
    load(0, 4,  enc_r(1, 2, 5, 6'b100100));
    load(0, 5,  enc_r(1, 2, 6, 6'b100101));
    load(0, 6,  enc_r(1, 2, 7, 6'b101010));
    load(0, 7,  enc_r(2, 1, 8, 6'b101010));
    load(0, 8,  enc_r(1, 2, 0, 6'b100000));
    load(0, 9,  enc_r(0, 1, 9, 6'b100000));
    load(0, 10, enc_i(6'b101011, 0, 3, 8));
    load(0, 11, enc_i(6'b101011, 0, 4, 12));
    load(0, 12, enc_i(6'b000100, 0, 0, -1));

    // R11: load port and debug read of a data word
    load(1, 5, 32'hA5A5_0F0F);
    rd_mem(5, v); check("R11 load port", v, 32'hA5A5_0F0F);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        a = operand(i);
        b = operand(j);
        @(negedge clk);
        rst = 1'b1;
        load(1, 0, a);
        load(1, 1, b);
        rd_reg(3, v);  check("R1 register cleared", v, 32'h0);
        rd_reg(9, v);  check("R1 register cleared", v, 32'h0);
        check("R1 pc reset", pc_out, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        run(1);
        check("R7 pc advance", pc_out, 32'd4);
        run(15);
        rd_reg(1, v);  check("R4 load first", v, a);
        rd_reg(2, v);  check("R4 load second", v, b);
        rd_reg(3, v);  check("R2 add", v, a + b);
        rd_reg(4, v);  check("R2 sub", v, a - b);
        rd_reg(5, v);  check("R2 and", v, a & b);
        rd_reg(6, v);  check("R2 or", v, a | b);
        rd_reg(7, v);  check("R3 slt a<b", v, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        rd_reg(8, v);  check("R3 slt b<a", v, ($signed(b) < $signed(a)) ? 32'd1 : 32'd0);
        rd_reg(0, v);  check("R6 r0 stays zero", v, 32'h0);
        rd_reg(9, v);  check("R6 r0 read as zero", v, a);
        rd_mem(2, v);  check("R5 store sum", v, a + b);
        rd_mem(3, v);  check("R5 store diff", v, a - b);
        check("R8 backward halt", pc_out, 32'd48);
      end
    end

    // control-flow program
    @(negedge clk);
    rst = 1'b1;
    load(0, 0,  enc_i(6'b100011, 0, 1, 0));
    load(0, 1,  enc_i(6'b100011, 0, 2, 4));
    load(0, 2,  enc_i(6'b000100, 1, 2, 2));
    load(0, 3,  enc_r(1, 2, 10, 6'b100000));
    load(0, 4,  enc_r(1, 2, 11, 6'b100000));
    load(0, 5,  enc_i(6'b000100, 1, 0, 1));
    load(0, 6,  enc_r(1, 2, 12, 6'b100000));
    load(0, 7,  {6'b000010, 26'd10});
    load(0, 8,  enc_r(1, 2, 13, 6'b100000));
    load(0, 9,  enc_r(1, 2, 14, 6'b100000));
    load(0, 10, {6'b111111, 5'd1, 5'd16, 16'h0000});
    load(0, 11, enc_r(1, 0, 15, 6'b100010));
    load(0, 12, enc_i(6'b000100, 0, 0, -1));
    load(1, 0, 32'd5);
    load(1, 1, 32'd5);
    @(negedge clk);
    rst = 1'b0;
    run(3);
    check("R8 taken forward", pc_out, 32'd20);
    run(1);
    check("R8 not taken", pc_out, 32'd24);
    run(2);
    check("R9 jump target", pc_out, 32'd40);
    run(1);
    check("R10 undefined advances", pc_out, 32'd44);
    run(20);
    rd_reg(10, v); check("R8 skipped r10", v, 32'h0);
    rd_reg(11, v); check("R8 skipped r11", v, 32'h0);
    rd_reg(12, v); check("R8 fall through", v, 32'd10);
    rd_reg(13, v); check("R9 skipped r13", v, 32'h0);
    rd_reg(14, v); check("R9 skipped r14", v, 32'h0);
    rd_reg(16, v); check("R10 no write", v, 32'h0);
    rd_reg(15, v); check("R9 landing", v, 32'd5);
    check("R8 halt loop", pc_out, 32'd48);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule